// File: doc/BRIEF.md
# SDRAM Presence-Detect Image Builder

This block turns a requested memory module description (a memory generation and a total capacity in MiB) into the 256-byte presence-detect image that a memory controller or boot agent reads to learn a module's geometry and timing. After a start pulse it latches the request. It then derives a legal bank count and per-bank density, and walks the whole image one byte per clock. Each walk step writes a byte into an internal buffer and adds the byte into a running checksum. The checksum is stored at byte 63.

Requests that cannot be met exactly are still honoured where possible. A capacity that is not a power of two is rounded down. A generation whose smallest legal size exceeds the request falls back to an older generation. Capacity that no bank arrangement can cover is dropped. Each of these adjustments raises its own sticky flag. A capacity under 4 MiB, or an unused generation code, raises an error flag and produces no image. Once done is high, any byte of the image can be read through a read port.

Top module: `spd_image_gen`

## Requirements
- R1: A request with `size_mib` below 4 or with `mem_type` equal to 3 sets `err_input`. Done rises one clock after the request is taken and no image is written. An error run never raises any warning flag.
- R2: The working size is floor(log2(`size_mib`)). `warn_trunc` is set when `size_mib` is not a power of two.
- R3: `mem_type` encodes 0 as SDR (log2 window 2..9), 1 as DDR (5..12) and 2 as DDR2 (7..14). If the working log2 is below the window minimum, the type becomes DDR when the rounded size is at least 32 MiB and SDR otherwise, and `warn_type` is set. Byte 2 holds the final type code: 4 for SDR, 7 for DDR, 8 for DDR2.
- R4: Starting from one bank, the log2 size drops by one and the bank count rises by one while the log2 size exceeds the window maximum and there are fewer than 8 banks. `warn_big` is set when banks times 2^log2 is below the rounded size. Byte 5 holds banks−1 for DDR2 and the bank count otherwise.
- R5: If the folding step leaves one bank and the log2 size exceeds the window minimum, the log2 size drops by one and the bank count becomes 2.
- R6: With d = 2^(log2−2), byte 31 holds d[7:0] for SDR, (d & 0xF8) | ((d>>8) & 0x07) for DDR, and (d & 0xE0) | ((d>>8) & 0x1F) for DDR2.
- R7: Fixed bytes: 0=128, 1=8, 3=13, 4=10, 6=64, 8=4, 9=0x25, 10=1, 12=0x82, 13=8, 16=12, 17=4, 18=12, 20=2, 23=0x12, 27=20, 28=15, 29=20, 30=45, 32=20, 33=8, 34=20, 35=8. Bytes 15 and 19 hold 0 for DDR2 and 1 otherwise.
- R8: Byte 63 holds the 8-bit sum of bytes 0..62. Every byte not named in R3..R7 is zero.
- R9: Busy rises on the edge that takes a start while idle, and lasts 257 clocks for a valid request. Done rises as busy falls. Done and all flags are cleared when the next request is taken, and otherwise hold their values.
- R10: A start pulse while busy is ignored; the image and flags follow the request already running.
- R11: After reset, busy, done and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| mem_type | input | 2 | Memory generation: 0 SDR, 1 DDR, 2 DDR2, 3 invalid |
| size_mib | input | SIZE_W | Module capacity in MiB |
| busy | output | 1 | Request being processed |
| done | output | 1 | Last request finished (sticky) |
| err_input | output | 1 | Size below 4 MiB or invalid type |
| warn_trunc | output | 1 | Size rounded down to a power of two |
| warn_type | output | 1 | Type fell back to an older generation |
| warn_big | output | 1 | Capacity exceeds what 8 banks can hold |
| rd_addr | input | ADDR_W | Image read address |
| rd_data | output | 8 | Image byte at rd_addr |

## Verification
A fault in the log2 folding or the type fallback shows up first on a warning flag, one clock after the request is taken. It then shows up in bytes 2, 5 and 31 and, through the sum, in byte 63 once done rises. A wrong walk counter or checksum accumulator leaves busy and done off from the 257-clock window, or corrupts byte 63 while the named bytes stay correct. So comparing the handshake on every clock and reading back the whole image after each run catches either fault within one request.

// File: rtl/spd_pkg.sv
package spd_pkg;

   typedef enum logic [1:0] {
      MT_SDR  = 2'd0,
      MT_DDR  = 2'd1,
      MT_DDR2 = 2'd2,
      MT_BAD  = 2'd3
   } mem_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CALC = 2'd1,
      ST_FILL = 2'd2
   } walk_state_e;

   localparam int unsigned CSUM_IDX = 63;

   function automatic int log_min(input mem_kind_e k);
      case (k)
         MT_SDR:  return 2;
         MT_DDR:  return 5;
         default: return 7;
      endcase
   endfunction

   function automatic int log_max(input mem_kind_e k);
      case (k)
         MT_SDR:  return 9;
         MT_DDR:  return 12;
         default: return 14;
      endcase
   endfunction

   function automatic logic [7:0] kind_code(input mem_kind_e k);
      case (k)
         MT_SDR:  return 8'd4;
         MT_DDR:  return 8'd7;
         default: return 8'd8;
      endcase
   endfunction

   // Content of one image byte, checksum position excluded.
   function automatic logic [7:0] image_field(input logic [7:0] idx, input mem_kind_e k,
                                              input logic [3:0] nb, input logic [7:0] dens);
      logic       is_d2;
      logic [7:0] v;
      is_d2 = (k == MT_DDR2);
      case (idx)
         8'd0:  v = 8'd128;
         8'd1:  v = 8'd8;
         8'd2:  v = kind_code(k);
         8'd3:  v = 8'd13;
         8'd4:  v = 8'd10;
         8'd5:  v = is_d2 ? {4'd0, nb - 4'd1} : {4'd0, nb};
         8'd6:  v = 8'd64;
         8'd8:  v = 8'd4;
         8'd9:  v = 8'h25;
         8'd10: v = 8'd1;
         8'd12: v = 8'h82;
         8'd13: v = 8'd8;
         8'd15: v = is_d2 ? 8'd0 : 8'd1;
         8'd16: v = 8'd12;
         8'd17: v = 8'd4;
         8'd18: v = 8'd12;
         8'd19: v = is_d2 ? 8'd0 : 8'd1;
         8'd20: v = 8'd2;
         8'd23: v = 8'h12;
         8'd27: v = 8'd20;
         8'd28: v = 8'd15;
         8'd29: v = 8'd20;
         8'd30: v = 8'd45;
         8'd31: v = dens;
         8'd32: v = 8'd20;
         8'd33: v = 8'd8;
         8'd34: v = 8'd20;
         8'd35: v = 8'd8;
         default: v = 8'd0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/spd_geometry.sv
module spd_geometry
   import spd_pkg::*;
#(
   parameter int unsigned SIZE_W = 16
) (
   input  mem_kind_e         kind_in,
   input  logic [SIZE_W-1:0] size_mib,
   output logic              bad,
   output logic              trunc,
   output logic              fallback,
   output logic              too_big,
   output mem_kind_e         kind_out,
   output logic [3:0]        banks,
   output logic [7:0]        dens_byte
);
   localparam int unsigned CAP_W = SIZE_W + 4;

   int                lg;
   int                sz;
   int                nb;
   int                mn;
   int                mx;
   logic [SIZE_W-1:0] pw;
   logic [CAP_W-1:0]  cap;
   logic [15:0]       dens;
   mem_kind_e         k;

   always_comb begin
      lg = 0;
      for (int b = 0; b < int'(SIZE_W); b++) begin
         if (size_mib[b]) lg = b;
      end
      pw = '0;
      pw[lg] = 1'b1;
      bad = (kind_in == MT_BAD) || (size_mib < SIZE_W'(4));
      trunc = !bad && (size_mib != pw);

      k = kind_in;
      fallback = 1'b0;
      if (!bad && (lg < log_min(kind_in))) begin
         fallback = 1'b1;
         k = (pw >= SIZE_W'(32)) ? MT_DDR : MT_SDR;
      end
      mn = log_min(k);
      mx = log_max(k);

      sz = lg;
      nb = 1;
      for (int i = 0; i < 7; i++) begin
         if ((sz > mx) && (nb < 8)) begin
            sz = sz - 1;
            nb = nb + 1;
         end
      end
      cap = CAP_W'(nb) << sz;
      too_big = !bad && (CAP_W'(pw) > cap);

      if ((nb == 1) && (sz > mn)) begin
         sz = sz - 1;
         nb = 2;
      end

      dens = (sz >= 2) ? (16'd1 << (sz - 2)) : 16'd0;
      case (k)
         MT_DDR2: dens_byte = (dens[7:0] & 8'hE0) | ({3'd0, dens[12:8]});
         MT_DDR:  dens_byte = (dens[7:0] & 8'hF8) | ({5'd0, dens[10:8]});
         default: dens_byte = dens[7:0];
      endcase
      kind_out = k;
      banks = 4'(nb);
   end

endmodule

// File: rtl/spd_image_buf.sv
module spd_image_buf #(
   parameter int unsigned ADDR_W   = 8,
   parameter bit          REG_READ = 1'b0
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (REG_READ) begin : g_reg_read
         always_ff @(posedge clk) rdata <= mem[raddr];
      end else begin : g_comb_read
         assign rdata = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/spd_image_gen.sv
module spd_image_gen
   import spd_pkg::*;
#(
   parameter int unsigned SIZE_W   = 16,
   parameter int unsigned ADDR_W   = 8,
   parameter bit          REG_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mem_type,
   input  logic [SIZE_W-1:0] size_mib,
   output logic              busy,
   output logic              done,
   output logic              err_input,
   output logic              warn_trunc,
   output logic              warn_type,
   output logic              warn_big,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   localparam logic [ADDR_W-1:0] LAST_IDX = '1;
   localparam logic [ADDR_W-1:0] SUM_IDX  = ADDR_W'(CSUM_IDX);

   generate
      if (SIZE_W < 6 || SIZE_W > 24) begin : g_bad_size_w
         $error("SIZE_W must lie in 6..24");
      end
      if (ADDR_W < 8 || ADDR_W > 12) begin : g_bad_addr_w
         $error("ADDR_W must lie in 8..12");
      end
   endgenerate

   walk_state_e       state_q;
   mem_kind_e         kind_q;
   logic [SIZE_W-1:0] size_q;
   logic [ADDR_W-1:0] idx_q;
   logic [7:0]        sum_q;
   logic              done_q;
   logic [3:0]        flags_q;

   logic              g_bad, g_trunc, g_fallback, g_big;
   mem_kind_e         g_kind;
   logic [3:0]        g_banks;
   logic [7:0]        g_dens;
   logic [7:0]        field;
   logic [7:0]        wbyte;
   logic              filling;

   spd_geometry #(.SIZE_W(SIZE_W)) u_geom (
      .kind_in  (kind_q),
      .size_mib (size_q),
      .bad      (g_bad),
      .trunc    (g_trunc),
      .fallback (g_fallback),
      .too_big  (g_big),
      .kind_out (g_kind),
      .banks    (g_banks),
      .dens_byte(g_dens)
   );

   assign filling = (state_q == ST_FILL);
   assign field   = ((idx_q >> 8) != '0) ? 8'd0 : image_field(idx_q[7:0], g_kind, g_banks, g_dens);
   assign wbyte   = (idx_q == SUM_IDX) ? sum_q : field;

   spd_image_buf #(.ADDR_W(ADDR_W), .REG_READ(REG_READ)) u_buf (
      .clk  (clk),
      .we   (filling),
      .waddr(idx_q),
      .wdata(wbyte),
      .raddr(rd_addr),
      .rdata(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= MT_SDR;
         size_q  <= '0;
         idx_q   <= '0;
         sum_q   <= '0;
         done_q  <= 1'b0;
         flags_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  kind_q  <= mem_kind_e'(mem_type);
                  size_q  <= size_mib;
                  done_q  <= 1'b0;
                  flags_q <= '0;
                  state_q <= ST_CALC;
               end
            end
            ST_CALC: begin
               flags_q <= {g_big, g_fallback, g_trunc, g_bad};
               idx_q   <= '0;
               sum_q   <= '0;
               if (g_bad) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (idx_q < SUM_IDX) sum_q <= sum_q + wbyte;
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign err_input  = flags_q[0];
   assign warn_trunc = flags_q[1];
   assign warn_type  = flags_q[2];
   assign warn_big   = flags_q[3];

endmodule

module spd_image_gen_chk #(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err_input,
   input logic              warn_trunc,
   input logic              warn_type,
   input logic              warn_big,
   input logic              filling,
   input logic [ADDR_W-1:0] idx
);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && !done));

   assert_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_err_alone_R1: assert property (@(posedge clk) disable iff (!rst_n)
      err_input |-> !(warn_trunc || warn_type || warn_big));

   assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      filling |=> $stable({err_input, warn_trunc, warn_type, warn_big}));

   assert_walk_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (filling && (idx != '1)) |=> (filling && (idx == $past(idx) + ADDR_W'(1))));

endmodule

bind spd_image_gen spd_image_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .err_input (err_input),
   .warn_trunc(warn_trunc),
   .warn_type (warn_type),
   .warn_big  (warn_big),
   .filling   (filling),
   .idx       (idx_q)
);

// File: tb/spd_image_gen_test.sv
module spd_image_gen_test;
   localparam int SIZE_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [1:0]        mem_type = 2'd0;
   logic [SIZE_W-1:0] size_mib = '0;
   logic [7:0]        rd_addr = '0;
   logic              busy, done, err_input, warn_trunc, warn_type, warn_big;
   logic [7:0]        rd_data;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   spd_image_gen #(.SIZE_W(SIZE_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type), .size_mib(size_mib),
      .busy(busy), .done(done), .err_input(err_input), .warn_trunc(warn_trunc),
      .warn_type(warn_type), .warn_big(warn_big), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always #4 clk = ~clk;

   // Reference image and flags, built from the requirements.
   int exp_img [256];
   bit exp_err, exp_tr, exp_ty, exp_bg;

   task automatic ref_build(input int t, input int sz);
      int lg, pw, mn, mx, nb, d, db, s;
      for (int i = 0; i < 256; i++) exp_img[i] = 0;
      exp_err = 0; exp_tr = 0; exp_ty = 0; exp_bg = 0;
      if (t == 3 || sz < 4) begin
         exp_err = 1;
         return;
      end
      lg = 0;
      while ((1 << (lg + 1)) <= sz) lg++;
      pw = 1 << lg;
      exp_tr = (pw != sz);
      mn = (t == 0) ? 2 : (t == 1) ? 5 : 7;
      if (lg < mn) begin
         exp_ty = 1;
         t = (pw >= 32) ? 1 : 0;
      end
      mn = (t == 0) ? 2 : (t == 1) ? 5 : 7;
      mx = (t == 0) ? 9 : (t == 1) ? 12 : 14;
      nb = 1;
      while (lg > mx && nb < 8) begin lg--; nb++; end
      exp_bg = (pw > (1 << lg) * nb);
      if (nb == 1 && lg > mn) begin lg--; nb = 2; end
      d = 1 << (lg - 2);
      if (t == 2)      db = (d & 'hE0) | ((d >> 8) & 'h1F);
      else if (t == 1) db = (d & 'hF8) | ((d >> 8) & 'h07);
      else             db = d & 'hFF;
      exp_img[0] = 128; exp_img[1] = 8; exp_img[2] = (t == 0) ? 4 : (t == 1) ? 7 : 8;
      exp_img[3] = 13; exp_img[4] = 10; exp_img[5] = (t == 2) ? nb - 1 : nb;
      exp_img[6] = 64; exp_img[8] = 4; exp_img[9] = 'h25; exp_img[10] = 1;
      exp_img[12] = 'h82; exp_img[13] = 8; exp_img[15] = (t == 2) ? 0 : 1;
      exp_img[16] = 12; exp_img[17] = 4; exp_img[18] = 12; exp_img[19] = (t == 2) ? 0 : 1;
      exp_img[20] = 2; exp_img[23] = 'h12; exp_img[27] = 20; exp_img[28] = 15;
      exp_img[29] = 20; exp_img[30] = 45; exp_img[31] = db; exp_img[32] = 20;
      exp_img[33] = 8; exp_img[34] = 20; exp_img[35] = 8;
      s = 0;
      for (int i = 0; i < 63; i++) s += exp_img[i];
      exp_img[63] = s & 255;
   endtask

   // Cycle model of the handshake and flags.
   bit m_busy = 0, m_done = 0, m_err = 0, m_tr = 0, m_ty = 0, m_bg = 0;
   int m_cnt = 0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_err = 0; m_tr = 0; m_ty = 0; m_bg = 0; m_cnt = 0;
      end else if (!m_busy) begin
         if (start) begin
            ref_build(int'(mem_type), int'(size_mib));
            m_busy = 1; m_done = 0; m_cnt = 0;
            m_err = 0; m_tr = 0; m_ty = 0; m_bg = 0;
         end
      end else begin
         m_cnt++;
         if (m_cnt == 1) begin
            m_err = exp_err; m_tr = exp_tr; m_ty = exp_ty; m_bg = exp_bg;
            if (exp_err) begin m_busy = 0; m_done = 1; end
         end else if (m_cnt == 257) begin
            m_busy = 0; m_done = 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == m_busy, "R9", "busy", busy, m_busy);
         chk(done == m_done, "R9", "done", done, m_done);
         chk(err_input == m_err, "R1", "err_input", err_input, m_err);
         chk(warn_trunc == m_tr, "R2", "warn_trunc", warn_trunc, m_tr);
         chk(warn_type == m_ty, "R3", "warn_type", warn_type, m_ty);
         chk(warn_big == m_bg, "R4", "warn_big", warn_big, m_bg);
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      while (cycles < 150000) @(posedge clk);
      chk(0, "R9", "watchdog expired", cycles, 0);
      finish_run();
   end

   task automatic launch(input int t, input int s);
      @(negedge clk);
      mem_type = 2'(t); size_mib = SIZE_W'(s); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!m_done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input int a, output int v);
      rd_addr = 8'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic check_image();
      int v;
      string tag;
      for (int a = 0; a < 256; a++) begin
         rd(a, v);
         if (a == 63)      tag = "R8";
         else if (a == 31) tag = "R6";
         else if (a == 5)  tag = "R4";
         else if (a == 2)  tag = "R3";
         else if (a > 35)  tag = "R8";
         else              tag = "R7";
         chk(v == exp_img[a], tag, $sformatf("byte %0d", a), v, exp_img[a]);
      end
   endtask

   task automatic spot(input int a, input int e, input string req);
      int v;
      rd(a, v);
      chk(v == e, req, $sformatf("spot byte %0d", a), v, e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(busy == 0 && done == 0, "R11", "busy/done at reset", {busy, done}, 0);
      chk({err_input, warn_trunc, warn_type, warn_big} == 4'b0, "R11", "flags at reset",
          {err_input, warn_trunc, warn_type, warn_big}, 0);
      rst_n = 1'b1;

      // R1: too small, then invalid type
      launch(0, 3); wait_done();
      chk(err_input == 1, "R1", "err for size 3", err_input, 1);
      launch(3, 100); wait_done();
      chk(err_input == 1, "R1", "err for type 3", err_input, 1);

      // R5: no split at window minimum; R11-style clearing of err on new request
      launch(0, 4);
      chk(err_input == 0, "R9", "err cleared on new start", err_input, 0);
      wait_done(); check_image();
      spot(31, 1, "R5"); spot(5, 1, "R5");

      // R2, R5, R6: DDR 100 MiB -> 64 rounded, split to 2 banks, density 8
      launch(1, 100); wait_done(); check_image();
      chk(warn_trunc == 1, "R2", "trunc for 100", warn_trunc, 1);
      spot(5, 2, "R5"); spot(31, 8, "R6"); spot(2, 7, "R3");

      // R3: DDR2 fallbacks
      launch(2, 64); wait_done(); check_image();
      chk(warn_type == 1, "R3", "fallback 64", warn_type, 1);
      spot(2, 7, "R3");
      launch(2, 16); wait_done(); check_image();
      spot(2, 4, "R3");

      // R4: folding without and with overflow
      launch(0, 1024); wait_done(); check_image();
      spot(5, 2, "R4"); spot(31, 128, "R4");
      launch(0, 65535); wait_done(); check_image();
      chk(warn_big == 1, "R4", "too big 65535 SDR", warn_big, 1);
      spot(5, 7, "R4");

      // R6, R7: DDR2 large
      launch(2, 65535); wait_done(); check_image();
      spot(5, 1, "R4"); spot(31, 'h10, "R6"); spot(15, 0, "R7"); spot(19, 0, "R7");

      // R6: DDR upper fold
      launch(1, 4096); wait_done(); check_image();

      // R10: start during busy ignored
      launch(0, 4);
      repeat (10) @(negedge clk);
      mem_type = 2'd2; size_mib = SIZE_W'(65535); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(); check_image();
      spot(31, 1, "R10"); spot(2, 4, "R10");
      chk(warn_trunc == 0, "R10", "flags of first request", warn_trunc, 0);

      finish_run();
   end

endmodule